// File: doc/BRIEF.md
# Audio Link Channel FIFO Status

This block serves one channel of a serial audio link. It holds a transmit FIFO, which software fills and the link framer drains one sample per slot. It also holds a receive FIFO, which the framer fills and software drains. From the occupancy of the two FIFOs and from the framer's frame-start strobe, it derives the channel's raw status flags. These are the full and empty flags, two half-level interrupt flags, a transmit-busy flag, a transmit-complete flag and a sticky receive-overrun flag.

The flags are packed into a 16-bit raw status word that is always visible on `stat_word`. Reading the word is passive. A write strobe on the same register, whatever the data, clears the overrun flag.

Transmit-busy follows link frames rather than occupancy alone. Once set, it holds through the frame in which the last sample leaves. It drops only at the next frame start that finds the FIFO empty. Enable changes do not shorten it.

Top module: `alink_chan_fifo_status`

## Requirements
- R1: After reset, with `tx_en` low, `stat_word` reads 16'h00C1. In that word bit 0 (transmit complete), bit 6 (transmit empty) and bit 7 (receive empty) are 1, and every other bit is 0.
- R2: Bit 4 is 1 exactly when the transmit FIFO holds 8 samples, and bit 5 is 1 exactly when the receive FIFO holds 8. Bit 6 is 1 exactly when the transmit FIFO is empty, and bit 7 is 1 exactly when the receive FIFO is empty. Bits 15:9 always read 0.
- R3: Both FIFOs return samples in push order. `tx_rdata` and `rx_rdata` show the oldest entry. A push into a full transmit FIFO is dropped, and a pop of an empty FIFO changes nothing.
- R4: Bit 1 (receive interrupt) is 1 exactly when the receive FIFO holds 4 or more samples.
- R5: Bit 2 (transmit interrupt) is 1 exactly when `tx_en` is high and the transmit FIFO holds 4 or fewer samples.
- R6: Bit 3 (transmit busy) becomes 1 on the clock edge where `tx_en` is high and the transmit FIFO holds data, or where `tx_pop` takes a sample.
- R7: Transmit busy stays 1 while the transmit FIFO holds data, even with `tx_en` low. It clears on the first `frame_start` edge that finds the FIFO empty with no pop in that cycle, whatever the level of `tx_en`.
- R8: A push into a full receive FIFO drops the sample and sets bit 8 (receive overrun). The bit stays set until the status register is written.
- R9: A `stat_wr` edge clears receive overrun. If an overflowing push arrives in the same cycle, the overrun stays set.
- R10: Bit 0 (transmit complete) is 1 exactly when the transmit FIFO is empty and no `tx_pop` has occurred since the last `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Transmit enable level for this channel |
| frame_start | input | 1 | One-cycle strobe at the start of each link frame |
| tx_push | input | 1 | Write `tx_wdata` into the transmit FIFO |
| tx_wdata | input | 20 | Transmit sample to store |
| tx_pop | input | 1 | Framer takes the oldest transmit sample for this frame |
| tx_rdata | output | 20 | Oldest transmit sample |
| rx_push | input | 1 | Framer writes `rx_wdata` into the receive FIFO |
| rx_wdata | input | 20 | Received sample |
| rx_pop | input | 1 | Remove the oldest receive sample |
| rx_rdata | output | 20 | Oldest receive sample |
| stat_wr | input | 1 | Write strobe on the raw status register, clears overrun |
| stat_word | output | 16 | Raw status word |

## Verification
Each strobe registers on the edge where it is high. Every flag in `stat_word`, and the FIFO heads, reflect that strobe one cycle after the edge, with no further pipeline. The bench therefore drives each strobe for exactly one clock. It samples 1 ns after the edge that takes the strobe, and it compares the whole status word against a word it builds from its own queues and its frame-level bookkeeping. Data checks happen before each pop edge, against the head of the scoreboard queue.

// File: rtl/alink_chan_fifo_status.sv
module alink_chan_fifo_status #(
  parameter int DW    = 20,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          frame_start,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_wdata,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_rdata,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_wdata,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_rdata,
  input  logic          stat_wr,
  output logic [15:0]   stat_word
);
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int HALF = DEPTH / 2;
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_C = CW'(HALF);
  localparam logic [AW-1:0] LAST_P = AW'(DEPTH - 1);

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;
  logic          busy_q, sent_q, ovr_q;

  wire tx_full  = (tx_cnt == FULL_C);
  wire tx_empty = (tx_cnt == '0);
  wire rx_full  = (rx_cnt == FULL_C);
  wire rx_empty = (rx_cnt == '0);

  wire tx_wr = tx_push && !tx_full;
  wire tx_rd = tx_pop  && !tx_empty;
  wire rx_wr = rx_push && !rx_full;
  wire rx_rd = rx_pop  && !rx_empty;

  wire rx_int   = (rx_cnt >= HALF_C);
  wire tx_int   = tx_en && (tx_cnt <= HALF_C);
  wire tx_cmpl  = tx_empty && !sent_q;
  wire busy_set = (tx_en && !tx_empty) || tx_rd;

  assign tx_rdata = tx_mem[tx_rp];
  assign rx_rdata = rx_mem[rx_rp];

  assign stat_word = {7'd0, ovr_q, rx_empty, tx_empty, rx_full, tx_full,
                      busy_q, tx_int, rx_int, tx_cmpl};

  always_ff @(posedge clk) begin
    if (tx_wr) tx_mem[tx_wp] <= tx_wdata;
    if (rx_wr) rx_mem[rx_wp] <= rx_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (tx_wr) tx_wp <= (tx_wp == LAST_P) ? '0 : tx_wp + 1'b1;
      if (tx_rd) tx_rp <= (tx_rp == LAST_P) ? '0 : tx_rp + 1'b1;
      if (rx_wr) rx_wp <= (rx_wp == LAST_P) ? '0 : rx_wp + 1'b1;
      if (rx_rd) rx_rp <= (rx_rp == LAST_P) ? '0 : rx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_wr) - CW'(tx_rd);
      rx_cnt <= rx_cnt + CW'(rx_wr) - CW'(rx_rd);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sent_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (busy_set)                      busy_q <= 1'b1;
      else if (frame_start && tx_empty)  busy_q <= 1'b0;

      if (tx_rd)            sent_q <= 1'b1;
      else if (frame_start) sent_q <= 1'b0;

      if (rx_push && rx_full) ovr_q <= 1'b1;
      else if (stat_wr)       ovr_q <= 1'b0;
    end
  end

  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_word[4] && stat_word[6]) && !(stat_word[5] && stat_word[7])); // R2
  AST_RX_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full && !rx_pop) |=> (ovr_q && rx_full)); // R8
  AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && !rx_push) |=> !ovr_q); // R9
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tx_empty) |=> busy_q); // R7
  AST_CMPL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cmpl |-> (tx_empty && !busy_q)); // R10
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= FULL_C) && (rx_cnt <= FULL_C)); // R3
endmodule

// File: tb/alink_chan_fifo_status_tb.sv
module alink_chan_fifo_status_tb;
  localparam int DW = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 0, frame_start = 0, tx_push = 0, tx_pop = 0;
  logic rx_push = 0, rx_pop = 0, stat_wr = 0;
  logic [DW-1:0] tx_wdata = '0, rx_wdata = '0, tx_rdata, rx_rdata;
  logic [15:0] stat_word;

  int checks = 0, errors = 0;
  logic [DW-1:0] tx_q[$], rx_q[$];
  logic exp_busy = 0, exp_sent = 0, exp_ovr = 0;

  always #4 clk = ~clk;

  alink_chan_fifo_status u_dut (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .frame_start(frame_start),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .stat_wr(stat_wr), .stat_word(stat_word));

  function automatic logic [15:0] exp_word();
    logic [15:0] w = '0;
    int tn = tx_q.size(), rn = rx_q.size();
    w[0] = (tn == 0) && !exp_sent;
    w[1] = rn >= 4;
    w[2] = tx_en && tn <= 4;
    w[3] = exp_busy;
    w[4] = tn == 8;
    w[5] = rn == 8;
    w[6] = tn == 0;
    w[7] = rn == 0;
    w[8] = exp_ovr;
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_word(input string req);
    chk(req, {16'd0, stat_word}, {16'd0, exp_word()});
  endtask

  task automatic tick();
    @(posedge clk); #1;
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; frame_start = 0; stat_wr = 0;
  endtask

  // driver: pushes expected items into the scoreboard queues
  task automatic tx_put(input logic [DW-1:0] d);
    tx_push = 1; tx_wdata = d;
    if (tx_q.size() < 8) tx_q.push_back(d);
    if (tx_en) exp_busy = 1;
    tick();
  endtask

  task automatic rx_put(input logic [DW-1:0] d);
    rx_push = 1; rx_wdata = d;
    if (rx_q.size() < 8) rx_q.push_back(d); else exp_ovr = 1;
    tick();
  endtask

  // monitor: pops the scoreboard and compares with the design's head
  task automatic tx_take();
    if (tx_q.size() > 0) begin
      chk("R3 tx order", {12'd0, tx_rdata}, {12'd0, tx_q.pop_front()});
      exp_busy = 1; exp_sent = 1;
    end
    tx_pop = 1;
    tick();
  endtask

  task automatic rx_take();
    if (rx_q.size() > 0) chk("R3 rx order", {12'd0, rx_rdata}, {12'd0, rx_q.pop_front()});
    rx_pop = 1;
    tick();
  endtask

  task automatic frame();
    frame_start = 1;
    if (tx_q.size() == 0 && !(tx_en && tx_q.size() > 0)) exp_busy = 0;
    exp_sent = 0;
    tick();
  endtask

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #20 rst_n = 1; #1;
    chk("R1 reset word", {16'd0, stat_word}, 32'h00C1);
    @(negedge clk);
    for (int i = 0; i < 3; i++) tx_put(20'h100 + i);
    chk_word("R2 R5 tx three, disabled");
    tx_en = 1; if (tx_q.size() > 0) exp_busy = 1; tick();
    chk_word("R6 R5 enable sets busy");
    for (int i = 3; i < 8; i++) begin
      tx_put(20'h100 + i);
      chk_word("R5 R2 tx fill");
    end
    tx_put(20'hDEAD0);
    chk_word("R3 R2 push to full tx dropped");
    tx_en = 0; tick();
    chk_word("R7 busy held with data, enable low");
    frame();
    chk_word("R7 frame with data keeps busy");
    for (int i = 0; i < 8; i++) begin
      tx_take();
      chk_word("R10 R7 tx drain");
    end
    tx_take();
    chk_word("R3 pop of empty tx ignored");
    tx_en = 1;
    frame();
    chk_word("R7 R10 frame clears busy, enable high");
    chk("R7 busy bit", {31'd0, stat_word[3]}, 32'd0);
    tx_en = 0;
    tx_put(20'h55555);
    chk_word("R6 push disabled no busy");
    tx_take();
    chk_word("R6 R10 pop sets busy");
    frame();
    chk_word("R10 complete after frame");

    for (int i = 0; i < 8; i++) begin
      rx_put(20'h200 + i);
      chk_word("R4 R2 rx fill");
    end
    rx_put(20'hBAD00);
    chk_word("R8 overflow sets overrun");
    tick();
    chk_word("R8 overrun sticky");
    stat_wr = 1; exp_ovr = 0; tick();
    chk_word("R9 write clears overrun");
    for (int i = 0; i < 8; i++) begin
      rx_take();
      chk_word("R4 R8 rx drain, dropped sample absent");
    end
    rx_take();
    chk_word("R3 pop of empty rx ignored");
    for (int i = 0; i < 8; i++) rx_put(20'h300 + i);
    stat_wr = 1; rx_put(20'hBAD01);
    chk_word("R9 overflow wins over write");
    stat_wr = 1; exp_ovr = 0; tick();
    chk_word("R9 later write clears");
    for (int i = 0; i < 8; i++) rx_take();
    chk_word("R2 rx empty again");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule